// File: doc/BRIEF.md
# EEPROM Page-Cache Write Sequencer

This block is the write path of a serial EEPROM. A write command opens a load session at a byte address. Data bytes then stream into a 64-byte cache, which is split into eight pages of eight bytes. The first byte lands at the in-page offset of the command address. Loading then advances through the cache, and past cache byte 63 it wraps to cache byte 0, where a newer byte replaces an older one.

The cache reaches the array only after the stop strobe. The block then walks the eight cache pages in order. Cache page k is programmed into array page (command page + k), which crosses into the next row and wraps from the top of the array to page 0. Each page with at least one loaded byte gets its own program pulse. The block then waits for the array to report that the write cycle is done before it moves on. A page with no loaded bytes is stepped over in one cycle without a program.

The byte stream uses valid/ready handshaking. A byte is taken in every cycle in which `in_valid` and `in_ready` are both high. `in_ready` is high only while a load session is open, and the source must hold `in_valid` and `in_data` steady until the byte is taken. Command strobes and the program interface are plain level and pulse signals.

Top module: `pcache_wr_seq`

## Requirements
- R1: During and right after reset, `busy`, `in_ready` and `prog_go` are 0.
- R2: A `cmd_start` pulse while the block is idle (not busy, no session open) opens a session, so `in_ready` is 1 from the next cycle. The first byte taken is placed at cache position `cmd_addr[2:0]`.
- R3: Each byte taken goes to the cache position after the previous one, modulo 64. When more than 64 bytes arrive, the later byte replaces the earlier one at the same position.
- R4: The transfer starts only after `cmd_stop` during a session. From the cycle after the stop, `busy` is 1 and `in_ready` is 0. `busy` stays 1 until the cycle after the last page is finished. A byte taken in the same cycle as the stop is still loaded.
- R5: Cache page k (cache positions 8k to 8k+7) is programmed to array page `(cmd_addr[11:3] + k) mod 512`, and the pages are visited in the order k = 0 to 7.
- R6: `prog_go` is a single-cycle pulse, one per programmed page. After a pulse, no further pulse is issued until `prog_done` has been seen high. The next page is handled in the cycle after `prog_done`.
- R7: During a pulse, `prog_be[i]` is 1 exactly when cache position 8k+i was loaded in the current command, and `prog_data[8i+7:8i]` then holds that byte.
- R8: A cache page with no loaded byte gets no `prog_go`. It takes one cycle, and the page address still advances past it.
- R9: `cmd_start` is ignored while a session is open or while `busy` is 1. `cmd_stop` is ignored while idle.
- R10: Each command starts with no positions marked as loaded, so bytes from an earlier command are never programmed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Write-command strobe |
| cmd_addr | input | 12 | Byte address of the write command |
| cmd_stop | input | 1 | Stop strobe that starts the transfer |
| in_valid | input | 1 | Data byte valid |
| in_ready | output | 1 | Block accepts a data byte |
| in_data | input | 8 | Data byte |
| prog_go | output | 1 | One-cycle page program pulse |
| prog_page | output | 9 | Array page address of the program |
| prog_be | output | 8 | Byte enables of the program |
| prog_data | output | 64 | Page data, byte i in bits 8i+7:8i |
| prog_done | input | 1 | Array write cycle finished |
| busy | output | 1 | Transfer in progress |

## Verification
A wrong load pointer or valid mask shows up at the first `prog_go` after the stop. It appears as the wrong enables or bytes for that page, or as a pulse where an empty page should have been skipped. A wrong base register or page counter shows up as a wrong `prog_page` on the same pulse. Sequencing faults show up on `busy` or `prog_go` within a cycle of the stop or of `prog_done`. These include starting early, not waiting for the write cycle to finish, or failing to end. The bench compares every output in every cycle against a behavioural model, and it also checks the whole array image after each command.

// File: rtl/pcache_wr_pkg.sv
package pcache_wr_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LOAD  = 2'd1,
    SEQ_FLUSH = 2'd2,
    SEQ_WAIT  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/pcache_ctrl.sv
module pcache_ctrl
  import pcache_wr_pkg::*;
#(
  parameter int CACHE_PAGES = 8,
  localparam int CIDX_W = $clog2(CACHE_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              in_valid,
  input  logic              page_any,
  input  logic              prog_done,
  output logic              capture,
  output logic              wr_en,
  output logic              in_ready,
  output logic              prog_go,
  output logic              busy,
  output logic [CIDX_W-1:0] page_idx
);
  seq_state_t state_q, state_d;
  logic [CIDX_W-1:0] idx_q, idx_d;
  logic last_page;

  assign last_page = (idx_q == CIDX_W'(CACHE_PAGES - 1));
  assign capture   = (state_q == SEQ_IDLE) && cmd_start;
  assign in_ready  = (state_q == SEQ_LOAD);
  assign wr_en     = in_ready && in_valid;
  assign prog_go   = (state_q == SEQ_FLUSH) && page_any;
  assign busy      = (state_q == SEQ_FLUSH) || (state_q == SEQ_WAIT);
  assign page_idx  = idx_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (cmd_start) state_d = SEQ_LOAD;
      end
      SEQ_LOAD: begin
        if (cmd_stop) begin
          state_d = SEQ_FLUSH;
          idx_d   = '0;
        end
      end
      SEQ_FLUSH: begin
        if (page_any) begin
          state_d = SEQ_WAIT;
        end else if (last_page) begin
          state_d = SEQ_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      SEQ_WAIT: begin
        if (prog_done) begin
          if (last_page) begin
            state_d = SEQ_IDLE;
          end else begin
            state_d = SEQ_FLUSH;
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> !prog_go);

  // R6
  hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WAIT && !prog_done) |=> (!prog_go && $stable(idx_q)));

  // R4
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_stop));
endmodule

// File: rtl/pcache_addr.sv
module pcache_addr #(
  parameter int ARRAY_BYTES = 4096,
  parameter int PAGE_BYTES  = 8,
  parameter int CACHE_PAGES = 8,
  localparam int ADDR_W  = $clog2(ARRAY_BYTES),
  localparam int OFF_W   = $clog2(PAGE_BYTES),
  localparam int CPTR_W  = $clog2(CACHE_PAGES * PAGE_BYTES),
  localparam int CIDX_W  = $clog2(CACHE_PAGES),
  localparam int PADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic               wr_en,
  input  logic [CIDX_W-1:0]  page_idx,
  output logic [CPTR_W-1:0]  wr_ptr,
  output logic [PADDR_W-1:0] prog_page
);
  logic [PADDR_W-1:0] base_q;
  logic [CPTR_W-1:0]  ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (capture) begin
      base_q <= cmd_addr[ADDR_W-1:OFF_W];
      ptr_q  <= CPTR_W'(cmd_addr[OFF_W-1:0]);
    end else if (wr_en) begin
      ptr_q  <= ptr_q + 1'b1;
    end
  end

  assign wr_ptr    = ptr_q;
  assign prog_page = base_q + PADDR_W'(page_idx);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !capture) |=> (wr_ptr == $past(wr_ptr) + 1'b1));
endmodule

// File: rtl/pcache_store.sv
module pcache_store #(
  parameter int PAGE_BYTES  = 8,
  parameter int CACHE_PAGES = 8,
  localparam int CACHE_BYTES = CACHE_PAGES * PAGE_BYTES,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int CPTR_W = $clog2(CACHE_BYTES),
  localparam int CIDX_W = $clog2(CACHE_PAGES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [CPTR_W-1:0]       wr_ptr,
  input  logic [7:0]              wr_data,
  input  logic [CIDX_W-1:0]       rd_page,
  output logic [PAGE_BYTES-1:0]   rd_be,
  output logic [PAGE_BYTES*8-1:0] rd_data,
  output logic                    rd_any
);
  logic [7:0]             mem_q [CACHE_BYTES];
  logic [CACHE_BYTES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_ptr] <= 1'b1;
    end
  end

  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE = OFF_W'(b);
    assign rd_be[b]          = vld_q[{rd_page, LANE}];
    assign rd_data[8*b +: 8] = mem_q[{rd_page, LANE}];
  end

  assign rd_any = |rd_be;

  // R3
  mark_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |=> vld_q[$past(wr_ptr)]);

  // R10
  mask_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vld_q == '0));
endmodule

// File: rtl/pcache_wr_seq.sv
module pcache_wr_seq #(
  parameter int ARRAY_BYTES = 4096,
  parameter int PAGE_BYTES  = 8,
  parameter int CACHE_PAGES = 8,
  localparam int ADDR_W  = $clog2(ARRAY_BYTES),
  localparam int OFF_W   = $clog2(PAGE_BYTES),
  localparam int CPTR_W  = $clog2(CACHE_PAGES * PAGE_BYTES),
  localparam int CIDX_W  = $clog2(CACHE_PAGES),
  localparam int PADDR_W = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_start,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic                    cmd_stop,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  output logic                    prog_go,
  output logic [PADDR_W-1:0]      prog_page,
  output logic [PAGE_BYTES-1:0]   prog_be,
  output logic [PAGE_BYTES*8-1:0] prog_data,
  input  logic                    prog_done,
  output logic                    busy
);
  logic              capture, wr_en, page_any;
  logic [CIDX_W-1:0] page_idx;
  logic [CPTR_W-1:0] wr_ptr;

  pcache_ctrl #(.CACHE_PAGES(CACHE_PAGES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .in_valid(in_valid), .page_any(page_any), .prog_done(prog_done),
    .capture(capture), .wr_en(wr_en), .in_ready(in_ready),
    .prog_go(prog_go), .busy(busy), .page_idx(page_idx)
  );

  pcache_addr #(
    .ARRAY_BYTES(ARRAY_BYTES), .PAGE_BYTES(PAGE_BYTES), .CACHE_PAGES(CACHE_PAGES)
  ) addr_i (
    .clk(clk), .rst_n(rst_n), .capture(capture), .cmd_addr(cmd_addr),
    .wr_en(wr_en), .page_idx(page_idx), .wr_ptr(wr_ptr), .prog_page(prog_page)
  );

  pcache_store #(.PAGE_BYTES(PAGE_BYTES), .CACHE_PAGES(CACHE_PAGES)) store_i (
    .clk(clk), .rst_n(rst_n), .clear(capture), .wr_en(wr_en),
    .wr_ptr(wr_ptr), .wr_data(in_data), .rd_page(page_idx),
    .rd_be(prog_be), .rd_data(prog_data), .rd_any(page_any)
  );

  // R8
  no_empty_program_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> (prog_be != '0));

  // R9
  stop_idle_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_ready && cmd_stop) |=> !busy);

  // R4
  no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
endmodule

// File: tb/pcache_wr_seq_tb.sv
module pcache_wr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [11:0] cmd_addr = '0;
  logic        cmd_stop = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        prog_go;
  logic [8:0]  prog_page;
  logic [7:0]  prog_be;
  logic [63:0] prog_data;
  logic        prog_done = 1'b0;
  logic        busy;

  always #4 clk = ~clk;

  pcache_wr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_stop(cmd_stop), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .prog_go(prog_go), .prog_page(prog_page),
    .prog_be(prog_be), .prog_data(prog_data), .prog_done(prog_done),
    .busy(busy)
  );

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;
  int resp_delay = 2;
  int resp_cnt   = 0;

  logic [7:0] arr_mem [4096];
  logic [7:0] exp_mem [4096];

  // behavioural model state
  int         ms = 0;
  int         mbase = 0, mptr = 0, midx = 0;
  logic [7:0] mc [64];
  bit         mm [64];

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_be();
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = mm[midx*8 + b];
    return r;
  endfunction

  // cycle model
  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mbase = 0; mptr = 0; midx = 0;
      for (int i = 0; i < 64; i++) mm[i] = 1'b0;
    end else begin
      case (ms)
        0: if (cmd_start) begin
             mbase = int'(cmd_addr) / 8;
             mptr  = int'(cmd_addr) % 8;
             for (int i = 0; i < 64; i++) mm[i] = 1'b0;
             ms = 1;
           end
        1: begin
             if (in_valid) begin
               mc[mptr] = in_data; mm[mptr] = 1'b1; mptr = (mptr + 1) % 64;
             end
             if (cmd_stop) begin ms = 2; midx = 0; end
           end
        2: if (exp_be() != 8'h00) ms = 3;
           else if (midx == 7) ms = 0;
           else midx++;
        default: if (prog_done) begin
             if (midx == 7) ms = 0;
             else begin midx++; ms = 2; end
           end
      endcase
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0]  be;
      logic [63:0] bm, ed;
      be = exp_be();
      chk("R4", "busy", 64'(busy), 64'(ms >= 2));
      chk("R2", "in_ready", 64'(in_ready), 64'(ms == 1));
      chk("R6/R8", "prog_go", 64'(prog_go), 64'(ms == 2 && be != 0));
      if (ms == 2 && be != 0) begin
        chk("R5", "prog_page", 64'(prog_page), 64'((mbase + midx) % 512));
        chk("R7", "prog_be", 64'(prog_be), 64'(be));
        for (int b = 0; b < 8; b++) begin
          bm[8*b +: 8] = {8{be[b]}};
          ed[8*b +: 8] = mc[midx*8 + b];
        end
        chk("R7", "prog_data", prog_data & bm, ed & bm);
      end
    end
  end

  // array responder
  always @(negedge clk) begin
    prog_done <= 1'b0;
    if (resp_cnt > 0) begin
      resp_cnt--;
      if (resp_cnt == 0) prog_done <= 1'b1;
    end
    if (rst_n && prog_go) begin
      for (int b = 0; b < 8; b++)
        if (prog_be[b]) arr_mem[int'(prog_page)*8 + b] = prog_data[8*b +: 8];
      resp_cnt = resp_delay;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      misses++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  task automatic run_cmd(input int addr, input int n, input int seed, input int gap,
                         input bit stop_with_last, input int delay,
                         input bit start_mid, input bit start_flush);
    logic [7:0] tv [64];
    bit         tm [64];
    int         bad = 0;
    int         first = -1;
    resp_delay = delay;
    for (int i = 0; i < 64; i++) tm[i] = 1'b0;
    @(negedge clk);
    cmd_start = 1'b1; cmd_addr = 12'(addr);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      cmd_start = 1'b0;
      if (gap != 0 && (j % gap) == gap - 1) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = 8'((seed * 31 + j * 7 + 3) & 255);
      tv[(addr % 8 + j) % 64] = in_data;
      tm[(addr % 8 + j) % 64] = 1'b1;
      cmd_stop = stop_with_last && (j == n - 1);
      if (start_mid && j == 2) begin cmd_start = 1'b1; cmd_addr = 12'h7F5; end
    end
    @(negedge clk);
    cmd_start = 1'b0; in_valid = 1'b0;
    if (!(stop_with_last && n > 0)) begin
      cmd_stop = 1'b1;
      @(negedge clk);
    end
    cmd_stop = 1'b0;
    @(negedge clk);
    chk("R4", "busy after stop", 64'(busy), 64'd1);
    if (start_flush) begin
      cmd_start = 1'b1; cmd_addr = 12'h000;
      @(negedge clk);
      cmd_start = 1'b0;
    end
    while (busy) @(negedge clk);
    // expected array image (R3 overwrite, R5 mapping, R10 only current bytes)
    for (int p = 0; p < 64; p++)
      if (tm[p]) exp_mem[((addr / 8 + p / 8) % 512) * 8 + p % 8] = tv[p];
    for (int a = 0; a < 4096; a++)
      if (arr_mem[a] !== exp_mem[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    chk("R5/R10", $sformatf("array image mismatches (first at %0d)", first),
        64'(bad), 64'd0);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) begin arr_mem[a] = 8'h00; exp_mem[a] = 8'h00; end
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 64'(busy), 64'd0);
    chk("R1", "prog_go in reset", 64'(prog_go), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready after reset", 64'(in_ready), 64'd0);
    // R5 aligned start at page 3 of row 5, crosses into row 6
    run_cmd(5*64 + 3*8, 64, 1, 0, 1'b0, 3, 1'b0, 1'b0);
    // R2 R3 offset 2 with wrap of last bytes, gaps for back-pressure
    run_cmd(9*64 + 3*8 + 2, 64, 2, 5, 1'b0, 1, 1'b0, 1'b0);
    // R3 overflow: 70 bytes overwrite the oldest
    run_cmd(20*64 + 5, 70, 3, 0, 1'b1, 2, 1'b0, 1'b0);
    // R8 partial: two pages used, six skipped; stop with last byte
    run_cmd(100, 5, 4, 0, 1'b1, 4, 1'b0, 1'b0);
    // R5 wrap from page 511 to page 0
    run_cmd(4096 - 16 + 1, 20, 5, 3, 1'b0, 1, 1'b0, 1'b0);
    // R8 empty command: all pages skipped
    run_cmd(200, 0, 6, 0, 1'b0, 1, 1'b0, 1'b0);
    // R9 start ignored during load and during flush
    run_cmd(33*64 + 7, 12, 7, 0, 1'b0, 2, 1'b1, 1'b1);
    // R10 a short rewrite must not reprogram older bytes
    run_cmd(5*64 + 3*8 + 1, 3, 8, 0, 1'b0, 1, 1'b0, 1'b0);
    // R9 stop while idle is ignored
    @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    @(negedge clk);
    chk("R9", "busy after idle stop", 64'(busy), 64'd0);
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule